// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. In each cycle it fetches a word from a small read-only program store and decodes it into datapath controls. It reads two operands from a register file, runs the ALU, optionally reads or writes the data memory, writes a result back, and computes the next program counter. It supports register-register arithmetic and logic, add-immediate, word load, word store and a branch taken on equality.

The program store is filled through the `PROGRAM` parameter. Word `i` sits at bits `[32*i +: 32]` and is fetched at byte address `4*i`. The data memory is a single-port word array inside the core. From outside, the core shows only clock and reset in, plus debug taps on the current PC and on every committed register-file write.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `dbg_pc` is 0 and `dbg_wr_en` is 0. After release, execution starts at address 0.
- R2: An instruction with opcode `[31:26]`=0x00 is a register operation on `rs`=`[25:21]` and `rt`=`[20:16]`, writing `rd`=`[15:11]`. The operation is chosen by funct `[5:0]`: 0x20 add, 0x22 subtract (rs-rt), 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 if rs<rt, else 0).
- R3: Opcode 0x08 writes `rt` with `rs` plus the sign-extended 16-bit immediate `[15:0]`.
- R4: Opcode 0x23 writes `rt` with the data-memory word at byte address `rs` + sign-extended immediate.
- R5: Opcode 0x2B stores `rt` to the data-memory word at byte address `rs` + sign-extended immediate, and makes no register-file write.
- R6: Opcode 0x04 compares `rs` and `rt` by subtraction. When the ALU zero flag is set, the next PC is PC+4+(sign-extended immediate × 4); otherwise it is PC+4. No register is written.
- R7: Register 0 always reads as 0. A write aimed at it is dropped and does not appear on `dbg_wr_en`.
- R8: An undefined opcode, or opcode 0x00 with an undefined funct, writes nothing and only advances the PC by 4.
- R9: Every instruction other than a taken branch advances the PC by 4. Register and memory writes take effect on the rising edge that ends the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_pc | output | XLEN | Byte address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register-file write commits at the end of this cycle |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | XLEN | Value being written |

## Verification
The hardest situations to reach are the ones with no direct trace on the ports. A store leaves no write on the debug taps, a write aimed at register 0 vanishes, and a branch shows only as a jump in the PC. The program is arranged so that each of these leaves a later, visible effect. Stored words are loaded back, one through a negative offset. Register 0 is read as an operand right after a write aimed at it. Both a taken and a not-taken branch run, and the taken one skips two instructions that would otherwise have written a register.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OPC_REG   = 6'h00;
   localparam logic [5:0] OPC_ADDI  = 6'h08;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_BEQ   = 6'h04;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_op_e;

   typedef struct packed {
      logic    reg_wr;      // commit a register write
      logic    dst_is_rd;   // destination field select
      logic    opb_is_imm;  // second operand select
      logic    mem_wr;      // data memory write
      logic    wb_from_mem; // write-back source select
      logic    branch;      // conditional PC redirect
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_fetch.sv
module sc_fetch #(
   parameter int XLEN       = 32,
   parameter int IMEM_WORDS = 32,
   parameter logic [IMEM_WORDS*32-1:0] PROGRAM = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_branch,
   input  logic [XLEN-1:0] branch_off,
   output logic [XLEN-1:0] pc,
   output logic [31:0]     instr
);
   localparam int IDX_W = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;

   generate
      if ((1 << IDX_W) != IMEM_WORDS) begin : g_bad_depth
         $error("IMEM_WORDS must be a power of two");
      end
      if (IDX_W + 2 > XLEN) begin : g_bad_span
         $error("program store larger than the address space");
      end
   endgenerate

   logic [XLEN-1:0]  pc_seq;
   logic [XLEN-1:0]  pc_next;
   logic [IDX_W-1:0] idx;

   assign pc_seq  = pc + XLEN'(4);
   assign pc_next = take_branch ? pc_seq + {branch_off[XLEN-3:0], 2'b00} : pc_seq;
   assign idx     = pc[IDX_W+1:2];
   assign instr   = PROGRAM[idx*32 +: 32];

   logic unused_pc_bits;
   assign unused_pc_bits = ^{pc[1:0], pc[XLEN-1:IDX_W+2], branch_off[XLEN-1:XLEN-2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_next;
   end

   assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !take_branch |=> pc == $past(pc) + XLEN'(4));

   assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_branch |=> pc == $past(pc) + XLEN'(4) + ($past(branch_off) << 2));

endmodule

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl
);
   always_comb begin
      ctl = '{reg_wr: 1'b0, dst_is_rd: 1'b0, opb_is_imm: 1'b0, mem_wr: 1'b0,
              wb_from_mem: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
      unique case (opcode)
         OPC_REG: begin
            ctl.dst_is_rd = 1'b1;
            ctl.reg_wr    = 1'b1;
            unique case (funct)
               FN_ADD:  ctl.alu_op = ALU_ADD;
               FN_SUB:  ctl.alu_op = ALU_SUB;
               FN_AND:  ctl.alu_op = ALU_AND;
               FN_OR:   ctl.alu_op = ALU_OR;
               FN_SLT:  ctl.alu_op = ALU_SLT;
               default: ctl.reg_wr = 1'b0;
            endcase
         end
         OPC_ADDI: begin
            ctl.reg_wr     = 1'b1;
            ctl.opb_is_imm = 1'b1;
         end
         OPC_LOAD: begin
            ctl.reg_wr      = 1'b1;
            ctl.opb_is_imm  = 1'b1;
            ctl.wb_from_mem = 1'b1;
         end
         OPC_STORE: begin
            ctl.opb_is_imm = 1'b1;
            ctl.mem_wr     = 1'b1;
         end
         OPC_BEQ: begin
            ctl.branch = 1'b1;
            ctl.alu_op = ALU_SUB;
         end
         default: ;
      endcase
   end

   always_comb begin
      assert_effects_exclusive_R8: assert ($onehot0({ctl.reg_wr, ctl.mem_wr, ctl.branch}));
   end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int XLEN              = 32,
   parameter int NREGS             = 32,
   parameter bit CLEAR_ON_RESET    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [4:0]      ra_addr,
   input  logic [4:0]      rb_addr,
   output logic [XLEN-1:0] ra_data,
   output logic [XLEN-1:0] rb_data,
   input  logic            we,
   input  logic [4:0]      wa,
   input  logic [XLEN-1:0] wd
);
   localparam int AW = 5;

   generate
      if (NREGS != (1 << AW)) begin : g_bad_nregs
         $error("NREGS must match the 5-bit register fields");
      end
   endgenerate

   logic [XLEN-1:0] regs [NREGS];
   logic            wr_ok;

   assign wr_ok   = we && (wa != '0);
   assign ra_data = regs[ra_addr];
   assign rb_data = regs[rb_addr];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREGS; i++) regs[i] <= '0;
            end else if (wr_ok) begin
               regs[wa] <= wd;
            end
         end
      end else begin : g_keep
         initial regs[0] = '0;
         always_ff @(posedge clk) begin
            if (wr_ok) regs[wa] <= wd;
         end
      end
   endgenerate

   always_comb begin
      if (rst_n) begin
         assert_zero_reg_reads_R7: assert (ra_addr != '0 || ra_data == '0);
      end
   end

   assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
   parameter int XLEN       = 32,
   parameter int DMEM_WORDS = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [XLEN-1:0] addr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);
   localparam int IDX_W = (DMEM_WORDS > 1) ? $clog2(DMEM_WORDS) : 1;

   generate
      if ((1 << IDX_W) != DMEM_WORDS) begin : g_bad_depth
         $error("DMEM_WORDS must be a power of two");
      end
   endgenerate

   logic [XLEN-1:0]  mem [DMEM_WORDS];
   logic [IDX_W-1:0] idx;

   assign idx   = addr[IDX_W+1:2];
   assign rdata = mem[idx];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{addr[1:0], addr[XLEN-1:IDX_W+2]};

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assert_store_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(idx)] == $past(wdata));

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IMEM_WORDS = 32,
   parameter int DMEM_WORDS = 64,
   parameter int NREGS      = 32,
   parameter bit RF_CLEAR_ON_RESET = 1'b1,
   parameter logic [IMEM_WORDS*32-1:0] PROGRAM = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] dbg_pc,
   output logic            dbg_wr_en,
   output logic [4:0]      dbg_wr_addr,
   output logic [XLEN-1:0] dbg_wr_data
);
   localparam int IMM_W = 16;

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("XLEN must hold a full instruction immediate");
      end
   endgenerate

   logic [XLEN-1:0] pc;
   logic [31:0]     instr;
   ctrl_t           ctl;
   logic [XLEN-1:0] imm_ext, opa, opb_reg, opb, alu_y, mem_q, wb_data;
   logic            alu_zero, take_branch, rf_we;
   logic [4:0]      f_rs, f_rt, f_rd, wb_addr;

   assign f_rs    = instr[25:21];
   assign f_rt    = instr[20:16];
   assign f_rd    = instr[15:11];
   assign imm_ext = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

   logic unused_shamt;
   assign unused_shamt = ^instr[10:6];

   sc_fetch #(.XLEN(XLEN), .IMEM_WORDS(IMEM_WORDS), .PROGRAM(PROGRAM)) u_fetch (
      .clk(clk), .rst_n(rst_n), .take_branch(take_branch),
      .branch_off(imm_ext), .pc(pc), .instr(instr));

   sc_decode u_decode (.opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

   sc_regfile #(.XLEN(XLEN), .NREGS(NREGS), .CLEAR_ON_RESET(RF_CLEAR_ON_RESET)) u_rf (
      .clk(clk), .rst_n(rst_n), .ra_addr(f_rs), .rb_addr(f_rt),
      .ra_data(opa), .rb_data(opb_reg), .we(rf_we), .wa(wb_addr), .wd(wb_data));

   assign opb = ctl.opb_is_imm ? imm_ext : opb_reg;

   sc_alu #(.XLEN(XLEN)) u_alu (.a(opa), .b(opb), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero));

   sc_dmem #(.XLEN(XLEN), .DMEM_WORDS(DMEM_WORDS)) u_dmem (
      .clk(clk), .rst_n(rst_n), .we(ctl.mem_wr && rst_n), .addr(alu_y),
      .wdata(opb_reg), .rdata(mem_q));

   assign take_branch = ctl.branch && alu_zero;
   assign wb_addr     = ctl.dst_is_rd ? f_rd : f_rt;
   assign wb_data     = ctl.wb_from_mem ? mem_q : alu_y;
   assign rf_we       = ctl.reg_wr && rst_n;

   assign dbg_pc      = pc;
   assign dbg_wr_en   = rf_we && (wb_addr != '0);
   assign dbg_wr_addr = wb_addr;
   assign dbg_wr_data = wb_data;

   always_comb begin
      if (rst_n && ctl.wb_from_mem) begin
         assert_load_writeback_R4: assert (wb_data == mem_q);
      end
      if (rst_n && ctl.mem_wr) begin
         assert_store_silent_R5: assert (!dbg_wr_en);
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> dbg_pc == '0);

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/100ps
module tb_sc_core;
   localparam int XLEN  = 32;
   localparam int IMEMW = 32;
   localparam int NROWS = 20;

   function automatic logic [31:0] rop(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] iop(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [IMEMW*32-1:0] build_prog();
      logic [IMEMW*32-1:0] p;
      p = '0;
      p[ 0*32 +: 32] = iop(6'h08, 0, 1, 16'd5);         // addi r1 = 5
      p[ 1*32 +: 32] = iop(6'h08, 0, 2, 16'hFFFD);      // addi r2 = -3
      p[ 2*32 +: 32] = rop(1, 2, 3, 6'h20);             // add r3
      p[ 3*32 +: 32] = rop(1, 2, 4, 6'h22);             // sub r4
      p[ 4*32 +: 32] = rop(1, 2, 5, 6'h24);             // and r5
      p[ 5*32 +: 32] = rop(1, 2, 6, 6'h25);             // or r6
      p[ 6*32 +: 32] = rop(2, 1, 7, 6'h2A);             // slt r7 = (r2<r1)
      p[ 7*32 +: 32] = iop(6'h2B, 1, 4, 16'd3);         // sw r4 -> 8
      p[ 8*32 +: 32] = iop(6'h23, 0, 8, 16'd8);         // lw r8 <- 8
      p[ 9*32 +: 32] = iop(6'h2B, 0, 2, 16'd20);        // sw r2 -> 20
      p[10*32 +: 32] = iop(6'h08, 0, 10, 16'd24);       // addi r10 = 24
      p[11*32 +: 32] = iop(6'h23, 10, 9, 16'hFFFC);     // lw r9 <- 24-4
      p[12*32 +: 32] = iop(6'h08, 0, 0, 16'd7);         // addi r0 = 7 (dropped)
      p[13*32 +: 32] = rop(0, 1, 11, 6'h20);            // add r11 = r0+r1
      p[14*32 +: 32] = iop(6'h04, 1, 11, 16'd2);        // beq taken -> 68
      p[15*32 +: 32] = iop(6'h08, 0, 12, 16'd99);       // skipped
      p[16*32 +: 32] = iop(6'h08, 0, 12, 16'd98);       // skipped
      p[17*32 +: 32] = iop(6'h04, 1, 2, 16'd5);         // beq not taken
      p[18*32 +: 32] = {6'h3F, 26'd0};                  // undefined opcode
      p[19*32 +: 32] = rop(1, 2, 13, 6'h3F);            // undefined funct
      p[20*32 +: 32] = iop(6'h04, 0, 0, 16'hFFFF);      // beq self loop
      return p;
   endfunction

   localparam logic [IMEMW*32-1:0] PROG = build_prog();

   // row: {pc, wr_en, wr_addr, wr_data}
   localparam logic [69:0] EXP [NROWS] = '{
      {32'd0,  1'b1, 5'd1,  32'd5},          // R3
      {32'd4,  1'b1, 5'd2,  32'hFFFFFFFD},   // R3 negative immediate
      {32'd8,  1'b1, 5'd3,  32'd2},          // R2 add
      {32'd12, 1'b1, 5'd4,  32'd8},          // R2 sub
      {32'd16, 1'b1, 5'd5,  32'd5},          // R2 and
      {32'd20, 1'b1, 5'd6,  32'hFFFFFFFD},   // R2 or
      {32'd24, 1'b1, 5'd7,  32'd1},          // R2 slt signed
      {32'd28, 1'b0, 5'd0,  32'd0},          // R5 store silent
      {32'd32, 1'b1, 5'd8,  32'd8},          // R4 load of stored word
      {32'd36, 1'b0, 5'd0,  32'd0},          // R5
      {32'd40, 1'b1, 5'd10, 32'd24},         // R3
      {32'd44, 1'b1, 5'd9,  32'hFFFFFFFD},   // R4 negative offset
      {32'd48, 1'b0, 5'd0,  32'd0},          // R7 write to r0 dropped
      {32'd52, 1'b1, 5'd11, 32'd5},          // R7 r0 reads zero
      {32'd56, 1'b0, 5'd0,  32'd0},          // R6 taken
      {32'd68, 1'b0, 5'd0,  32'd0},          // R6 target, not taken
      {32'd72, 1'b0, 5'd0,  32'd0},          // R8 undefined opcode
      {32'd76, 1'b0, 5'd0,  32'd0},          // R8 undefined funct
      {32'd80, 1'b0, 5'd0,  32'd0},          // R9 then R6 self loop
      {32'd80, 1'b0, 5'd0,  32'd0}           // R6
   };
   string ROW_REQ [NROWS] = '{"R3","R3","R2","R2","R2","R2","R2","R5","R4","R5",
                              "R3","R4","R7","R7","R6","R6","R8","R8","R9","R6"};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [XLEN-1:0] dbg_pc, dbg_wr_data;
   logic            dbg_wr_en;
   logic [4:0]      dbg_wr_addr;
   int              n_chk = 0;
   int              n_bad = 0;

   always #2 clk = ~clk;

   sc_core #(.XLEN(XLEN), .IMEM_WORDS(IMEMW), .PROGRAM(PROG)) dut (
      .clk(clk), .rst_n(rst_n), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
      .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_row(input int i);
      logic [69:0] r;
      r = EXP[i];
      chk(ROW_REQ[i], $sformatf("row %0d pc", i), dbg_pc, r[69:38]);
      chk(ROW_REQ[i], $sformatf("row %0d wr_en", i), 32'(dbg_wr_en), 32'(r[37]));
      if (r[37]) begin
         chk(ROW_REQ[i], $sformatf("row %0d wr_addr", i), 32'(dbg_wr_addr), 32'(r[36:32]));
         chk(ROW_REQ[i], $sformatf("row %0d wr_data", i), dbg_wr_data, r[31:0]);
      end
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "pc in reset", dbg_pc, 32'd0);
      chk("R1", "wr_en in reset", 32'(dbg_wr_en), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NROWS; i++) begin
         #1 check_row(i);
         @(negedge clk);
      end
      // R1: reset in the middle of the self loop
      rst_n = 1'b0;
      #1;
      chk("R1", "pc after mid-run reset", dbg_pc, 32'd0);
      chk("R1", "wr_en after mid-run reset", 32'(dbg_wr_en), 32'd0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: execution restarts from address 0
      for (int i = 0; i < 4; i++) begin
         #1 check_row(i);
         @(negedge clk);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule